// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This peripheral sits on a simple register read/write port and multiplies two operands that software writes into it. The address used for the first operand selects the operation: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. The operation runs when the second operand is written. The 32-bit result sits in a low word and a high word. A third word, the sum extension, holds either the sign of a signed result or the carry out of an unsigned accumulation.

Each operand can be written as a full word or as a byte. A byte is widened to a word according to the selected mode, so the unit covers 16x16, 16x8, 8x16 and 8x8 products. The product lands in the result registers on the same clock edge that accepts the second operand. The next bus access can therefore read it with no wait cycles. Both result words can be written, which lets software preload the accumulator.

Top module: `mmac_unit`

## Requirements
- R1: After reset the two result words, the sum extension and both operand registers read 0, and the mode is unsigned multiply.
- R2: Writing the first operand at word address 0 selects unsigned multiply. A write of the second operand (address 4) then sets the result words (5 = low, 6 = high) to the unsigned product, and the sum extension (7) to 0.
- R3: Writing the first operand at address 1 selects signed multiply. The result is the two's-complement product, and the sum extension is 0xFFFF when that product is negative and 0 otherwise.
- R4: Writing the first operand at address 2 selects unsigned accumulate. The product is added to the current 32-bit result, and the sum extension becomes the carry out of that addition (0 or 1).
- R5: Writing the first operand at address 3 selects signed accumulate. The signed product is added to the current result modulo 2^32, and the sum extension is 0xFFFF when the new result is negative and 0 otherwise.
- R6: With the byte strobe high, only data bits 7:0 are taken. They are zero-extended in unsigned modes and sign-extended in signed modes. For the second operand the mode latched by the last first-operand write applies.
- R7: The first operand and mode are retained. A further second-operand write repeats the operation with the same first operand, and in accumulate modes it adds again.
- R8: The result words can be written at addresses 5 and 6 to preload the accumulator. Writes to address 7 have no effect.
- R9: The result and sum extension change only on a second-operand write or a result-word write. A first-operand write leaves them unchanged.
- R10: Reads of addresses 0 to 3 return the stored (widened) first operand, and a read of address 4 returns the stored second operand.
- R11: The result of a second-operand write is readable on the read port in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word address for read and write |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_byte | input | 1 | Byte write: only bits 7:0 of the data are used |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
The operands and the mode register take their new values on the write edge. The result words and the sum extension are registered on the same edge as the second-operand write, so they are due one edge after that write. Reads are combinational from the address. The bench therefore drives each write half a cycle before its edge. It sets the read address at the following falling edge and samples a short delay later, which is the first access after the write. Expected values come from a wide-integer model of the four modes, and several cases are also compared against hand-computed constants.

// File: rtl/mmac_pkg.sv
// Shared types and address map of the multiply-accumulate unit.
// Assumes a 3-bit word address; first-operand addresses encode the mode in bits 1:0.
package mmac_pkg;

    // bit 0: signed operands, bit 1: accumulate into result
    typedef enum logic [1:0] {
        MODE_MPYU = 2'd0,
        MODE_MPYS = 2'd1,
        MODE_MACU = 2'd2,
        MODE_MACS = 2'd3
    } mac_mode_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_OP2  = 3'd4;
    localparam logic [ADDR_W-1:0] A_RLO  = 3'd5;
    localparam logic [ADDR_W-1:0] A_RHI  = 3'd6;
    localparam logic [ADDR_W-1:0] A_SEXT = 3'd7;

    function automatic logic mode_signed(input mac_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_accum(input mac_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/mmac_ext.sv
// Operand widener: passes a full word, or widens the low half-word when a
// byte is written, zero- or sign-extending according to sgn.
// Assumes DW is even.
module mmac_ext #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] din,
    input  logic          byte_sel,
    input  logic          sgn,
    output logic [DW-1:0] dout
);
    localparam int HW = DW / 2;

    logic fill;

    // choose the fill bit and assemble the widened operand
    always_comb begin
        fill = sgn & din[HW-1];
        if (byte_sel)
            dout = {{HW{fill}}, din[HW-1:0]};
        else
            dout = din;
    end
endmodule

// File: rtl/mmac_mul.sv
// Combinational multiplier: treats both operands as signed or unsigned
// and returns the low 2*DW bits of the exact product.
// Assumes both operands share one signedness.
module mmac_mul #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            sgn,
    output logic [2*DW-1:0] prod
);
    localparam int PW = 2 * DW + 2;

    logic signed [DW:0]   ax;
    logic signed [DW:0]   bx;
    logic signed [PW-1:0] full;

    // extend by one bit so one signed multiplier serves both modes
    always_comb begin
        ax   = {sgn & a[DW-1], a};
        bx   = {sgn & b[DW-1], b};
        full = PW'(ax) * PW'(bx);
        prod = full[2*DW-1:0];
    end
endmodule

// File: rtl/mmac_acc.sv
// Result stage: picks the product or the accumulated sum as the next
// result and forms the sum-extension word for the selected mode.
// Assumes prev is the current registered result.
module mmac_acc
    import mmac_pkg::*;
#(
    parameter int DW = 16
) (
    input  mac_mode_e       mode,
    input  logic [2*DW-1:0] prev,
    input  logic [2*DW-1:0] prod,
    output logic [2*DW-1:0] nxt,
    output logic [DW-1:0]   sext
);
    localparam int RW = 2 * DW;

    logic [RW:0] usum;

    // form the next result and its extension word
    always_comb begin
        usum = {1'b0, prev} + {1'b0, prod};
        nxt  = mode_accum(mode) ? usum[RW-1:0] : prod;
        case (mode)
            MODE_MPYU: sext = '0;
            MODE_MPYS: sext = {DW{prod[RW-1]}};
            MODE_MACU: sext = {{(DW-1){1'b0}}, usum[RW]};
            default:   sext = {DW{usum[RW-1]}};
        endcase
    end
endmodule

// File: rtl/mmac_unit.sv
// Register-mapped multiply-accumulate unit. The first operand's address
// picks the mode; the second-operand write registers the result on the
// same edge. Reads are combinational from bus_addr.
// Assumes one access per cycle and no wait states on the bus.
module mmac_unit
    import mmac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_byte,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);
    localparam int RW = 2 * DW;

    mac_mode_e       mode_q;
    logic [DW-1:0]   op1_q;
    logic [DW-1:0]   op2_q;
    logic [RW-1:0]   res_q;
    logic [DW-1:0]   sext_q;

    logic            wr_op1;
    logic            wr_op2;
    logic            wr_rlo;
    logic            wr_rhi;
    mac_mode_e       new_mode;
    logic [DW-1:0]   op1_in;
    logic [DW-1:0]   op2_in;
    logic [RW-1:0]   prod;
    logic [RW-1:0]   res_nxt;
    logic [DW-1:0]   sext_nxt;

    // decode the write strobe into register selects
    always_comb begin
        wr_op1   = bus_wr && (bus_addr[ADDR_W-1] == 1'b0);
        wr_op2   = bus_wr && (bus_addr == A_OP2);
        wr_rlo   = bus_wr && (bus_addr == A_RLO);
        wr_rhi   = bus_wr && (bus_addr == A_RHI);
        new_mode = mac_mode_e'(bus_addr[1:0]);
    end

    mmac_ext #(.DW(DW)) u_ext1 (
        .din      (bus_wdata),
        .byte_sel (bus_byte),
        .sgn      (mode_signed(new_mode)),
        .dout     (op1_in)
    );

    mmac_ext #(.DW(DW)) u_ext2 (
        .din      (bus_wdata),
        .byte_sel (bus_byte),
        .sgn      (mode_signed(mode_q)),
        .dout     (op2_in)
    );

    mmac_mul #(.DW(DW)) u_mul (
        .a    (op1_q),
        .b    (op2_in),
        .sgn  (mode_signed(mode_q)),
        .prod (prod)
    );

    mmac_acc #(.DW(DW)) u_acc (
        .mode (mode_q),
        .prev (res_q),
        .prod (prod),
        .nxt  (res_nxt),
        .sext (sext_nxt)
    );

    // operand and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_MPYU;
            op1_q  <= '0;
            op2_q  <= '0;
        end else begin
            if (wr_op1) begin
                mode_q <= new_mode;
                op1_q  <= op1_in;
            end
            if (wr_op2)
                op2_q <= op2_in;
        end
    end

    // result and sum-extension registers, updated on the operand-2 edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            sext_q <= '0;
        end else if (wr_op2) begin
            res_q  <= res_nxt;
            sext_q <= sext_nxt;
        end else if (wr_rlo) begin
            res_q[DW-1:0] <= bus_wdata;
        end else if (wr_rhi) begin
            res_q[RW-1:DW] <= bus_wdata;
        end
    end

    // read multiplexer
    always_comb begin
        case (bus_addr)
            A_OP2:   bus_rdata = op2_q;
            A_RLO:   bus_rdata = res_q[DW-1:0];
            A_RHI:   bus_rdata = res_q[RW-1:DW];
            A_SEXT:  bus_rdata = sext_q;
            default: bus_rdata = op1_q;
        endcase
    end

    // R2
    umpy_sext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == MODE_MPYU) |=> (sext_q == '0));

    // R3
    smpy_sext_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == MODE_MPYS) |=> (sext_q == {DW{res_q[RW-1]}}));

    // R4
    umac_carry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == MODE_MACU) |=> ((sext_q >> 1) == '0));

    // R5
    smac_sext_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op2 && mode_q == MODE_MACS) |=> (sext_q == {DW{res_q[RW-1]}}));

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_op2 || wr_rlo || wr_rhi) |=> $stable(res_q));

    // R8
    sext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_op2 |=> $stable(sext_q));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_op1 |=> $stable(mode_q));
endmodule

// File: tb/tb_mmac_unit.sv
module tb_mmac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_byte = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] m_res = '0;
    logic [15:0] m_sext = '0;
    logic [1:0]  m_mode = '0;
    logic [15:0] m_op1 = '0;

    mmac_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: got hang, exp completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_byte = b; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_byte = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [15:0] widen(input logic [15:0] d, input logic b, input logic s);
        if (!b) return d;
        return {{8{s & d[7]}}, d[7:0]};
    endfunction

    // reference model of one operand-2 write
    task automatic model(input logic [15:0] b);
        longint pa, pb, p;
        logic [32:0] u;
        pa = m_mode[0] ? longint'($signed(m_op1)) : longint'({48'd0, m_op1});
        pb = m_mode[0] ? longint'($signed(b)) : longint'({48'd0, b});
        p = pa * pb;
        if (!m_mode[1]) begin
            m_res = p[31:0];
            m_sext = m_mode[0] ? {16{m_res[31]}} : 16'h0;
        end else begin
            u = {1'b0, m_res} + {1'b0, p[31:0]};
            m_res = u[31:0];
            m_sext = m_mode[0] ? {16{m_res[31]}} : {15'd0, u[32]};
        end
    endtask

    task automatic set_op1(input logic [1:0] m, input logic [15:0] d, input logic b);
        wr({1'b0, m}, d, b);
        m_mode = m;
        m_op1 = widen(d, b, m[0]);
    endtask

    task automatic set_op2(input string tag, input logic [15:0] d, input logic b);
        logic [15:0] v;
        wr(3'd4, d, b);
        model(widen(d, b, m_mode[0]));
        rd(3'd5, v); chk({tag, " lo"}, v, m_res[15:0]);
        rd(3'd6, v); chk({tag, " hi"}, v, m_res[31:16]);
        rd(3'd7, v); chk({tag, " sext"}, v, m_sext);
    endtask

    task automatic preload(input logic [31:0] r);
        wr(3'd5, r[15:0], 1'b0);
        wr(3'd6, r[31:16], 1'b0);
        m_res = r;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            chk("R1 reset read", v, 16'h0);
        end
    endtask

    task automatic t_umpy;
        logic [15:0] v;
        set_op1(2'd0, 16'hFFFF, 1'b0);
        set_op2("R2 umpy ffff*ffff", 16'hFFFF, 1'b0);
        rd(3'd6, v); chk("R2 umpy const hi", v, 16'hFFFE);
        rd(3'd5, v); chk("R11 umpy const lo next access", v, 16'h0001);
        set_op1(2'd0, 16'h1234, 1'b0);
        set_op2("R2 umpy 1234*5678", 16'h5678, 1'b0);
    endtask

    task automatic t_smpy;
        logic [15:0] v;
        set_op1(2'd1, 16'hFFFF, 1'b0);
        set_op2("R3 smpy -1*2", 16'h0002, 1'b0);
        rd(3'd7, v); chk("R3 smpy neg sext const", v, 16'hFFFF);
        set_op1(2'd1, 16'h7FFF, 1'b0);
        set_op2("R3 smpy max*max", 16'h7FFF, 1'b0);
        rd(3'd6, v); chk("R3 smpy const hi", v, 16'h3FFF);
        set_op1(2'd1, 16'h8000, 1'b0);
        set_op2("R3 smpy min*min", 16'h8000, 1'b0);
    endtask

    task automatic t_umac;
        logic [15:0] v;
        preload(32'hFFFF_FFFF);
        set_op1(2'd2, 16'h0001, 1'b0);
        set_op2("R4 umac carry", 16'h0001, 1'b0);
        rd(3'd7, v); chk("R4 umac carry const", v, 16'h0001);
        set_op2("R4 umac no carry", 16'h0003, 1'b0);
        rd(3'd5, v); chk("R4 umac const lo", v, 16'h0003);
    endtask

    task automatic t_smac;
        logic [15:0] v;
        preload(32'h0000_0005);
        set_op1(2'd3, 16'hFFFD, 1'b0);
        set_op2("R5 smac 5+(-3*2)", 16'h0002, 1'b0);
        rd(3'd6, v); chk("R5 smac const hi", v, 16'hFFFF);
        set_op2("R5 smac -1+(-3*-4)", 16'hFFFC, 1'b0);
        rd(3'd5, v); chk("R5 smac const lo", v, 16'h000B);
    endtask

    task automatic t_bytes;
        logic [15:0] v;
        set_op1(2'd1, 16'hAB80, 1'b1);
        rd(3'd1, v); chk("R6 signed byte op1", v, 16'hFF80);
        set_op2("R6 smpy 8x8", 16'hCD02, 1'b1);
        rd(3'd5, v); chk("R6 smpy 8x8 const lo", v, 16'hFF00);
        set_op1(2'd0, 16'h1280, 1'b1);
        rd(3'd0, v); chk("R6 unsigned byte op1", v, 16'h0080);
        set_op2("R6 umpy 8x8", 16'hABFF, 1'b1);
        rd(3'd5, v); chk("R6 umpy 8x8 const lo", v, 16'h7F80);
        set_op1(2'd1, 16'h8000, 1'b0);
        set_op2("R6 smpy 16x8", 16'h00FE, 1'b1);
        rd(3'd4, v); chk("R10 op2 readback", v, 16'hFFFE);
    endtask

    task automatic t_repeat;
        preload(32'h0);
        set_op1(2'd2, 16'h0100, 1'b0);
        set_op2("R7 mac first", 16'h0010, 1'b0);
        set_op2("R7 mac repeat", 16'h0010, 1'b0);
    endtask

    task automatic t_ignore;
        logic [15:0] v;
        set_op1(2'd1, 16'hFFFF, 1'b0);
        set_op2("R8 setup", 16'h0003, 1'b0);
        wr(3'd7, 16'h1234, 1'b0);
        rd(3'd7, v); chk("R8 sext write ignored", v, m_sext);
        set_op1(2'd3, 16'h5555, 1'b0);
        rd(3'd5, v); chk("R9 op1 write keeps lo", v, m_res[15:0]);
        rd(3'd6, v); chk("R9 op1 write keeps hi", v, m_res[31:16]);
        rd(3'd7, v); chk("R9 op1 write keeps sext", v, m_sext);
        rd(3'd3, v); chk("R10 op1 readback", v, 16'h5555);
        rd(3'd2, v); chk("R10 op1 readback alias", v, 16'h5555);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_umpy;
        t_smpy;
        t_umac;
        t_smac;
        t_bytes;
        t_repeat;
        t_ignore;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule